// File: doc/BRIEF.md
# Per-Channel Edge Event Latch with Interrupt

This block watches a vector of already-debounced digital inputs and records, per channel, when that channel makes its selected transition. Each channel chooses whether a rising edge or a falling edge counts. It can also be set to count both edges, which is change-of-state detection. A channel records nothing unless its own event enable bit is set. A recorded event stays pending until software writes a one to that channel's bit of the clear register.

A single interrupt line is the OR of all pending flags, gated by a global interrupt enable bit. This enable gates only the line. Capture goes on while it is off, and the pending vector can always be read back for polling. Configuration arrives over a simple one-cycle write port that selects one of five registers. The pending flags come out as a registered vector.

Top module: `evt_capture_top`

## Requirements
- R1: After reset the pending vector is all zero, the interrupt output is low, every channel's polarity is falling and every channel's event enable is 0. With those settings a rising edge on channel 0 latches nothing, and a falling edge latches only once the enable has been written.
- R2: On an enabled channel in single-edge mode (change-of-state bit 0), polarity bit 0 latches on a 1-to-0 transition and polarity bit 1 latches on a 0-to-1 transition. The polarity register is written with select 0.
- R3: A channel whose enable bit is 0 never sets its pending flag, whatever its input does. The enable register is written with select 1.
- R4: A channel whose change-of-state bit is 1 latches on both transitions, whatever its polarity bit holds. This register is written with select 2.
- R5: A write with select 3 clears each pending flag whose data bit is 1. A data bit of 0 leaves that flag unchanged.
- R6: When a new qualifying edge and a write-1 clear hit the same channel in the same cycle, the flag ends up set.
- R7: The interrupt output is a level equal to bit 0 of the enable register written with select 4, ANDed with the OR of all pending flags. It follows the pending flags one cycle later. While the enable bit is 0 the pending flags can still be read and keep their values.
- R8: An edge that happened while a channel was disabled is not latched when the channel is enabled later. Only edges that occur after the enable takes effect count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NCH | Debounced input levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Register select: 0 polarity, 1 enable, 2 change-of-state, 3 clear, 4 interrupt enable |
| wr_data | input | NCH | Write data, one bit per channel (bit 0 only for select 4) |
| pend_o | output | NCH | Pending event flags |
| irq_o | output | 1 | Interrupt request level |

## Verification
The assertions assume that `din` is already synchronous to `clk` and changes at most once per cycle per bit. They also assume that every write is a single-cycle strobe, so that a new flag can always be traced back to an enabled channel and a dropped flag to a clear write in the cycle before. The stimulus changes `din` and the write port only on the falling clock edge, issues one register write at a time, and lets each change settle for several cycles before a check. The one deliberate overlap is the same-cycle edge and clear that R6 calls for.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_POL = 3'd0,
    SEL_EN  = 3'd1,
    SEL_COS = 3'd2,
    SEL_CLR = 3'd3,
    SEL_IEN = 3'd4
  } evt_sel_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int NCH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NCH-1:0]   wr_data,
  output logic [NCH-1:0]   pol_o,
  output logic [NCH-1:0]   en_o,
  output logic [NCH-1:0]   cos_o,
  output logic [NCH-1:0]   clr_o,
  output logic             ien_o
);
  logic [NCH-1:0] pol_q, en_q, cos_q;
  logic           ien_q;
  evt_sel_e       sel;

  assign sel = evt_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      en_q  <= '0;
      cos_q <= '0;
      ien_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_POL: pol_q <= wr_data;
        SEL_EN:  en_q  <= wr_data;
        SEL_COS: cos_q <= wr_data;
        SEL_IEN: ien_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  // clear is a pulse, applied in the same edge as the write
  assign clr_o = (wr_en && sel == SEL_CLR) ? wr_data : '0;
  assign pol_o = pol_q;
  assign en_o  = en_q;
  assign cos_o = cos_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int NCH = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] din,
  input  logic [NCH-1:0] pol,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] cos,
  output logic [NCH-1:0] hit_o
);
  // previous level keeps tracking on every channel, enabled or not
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rise, fall, sel_edge;
    assign rise     = din[c] & ~prev_q[c];
    assign fall     = ~din[c] & prev_q[c];
    assign sel_edge = cos[c] ? (rise | fall) : (pol[c] ? rise : fall);
    assign hit_o[c] = en[c] & sel_edge;
  end
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int NCH = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] pend_q;

  // set wins over clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end

  assign pend_o = pend_q;

  // R5
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr)) == '0));

  // R6
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit) & ~pend_q) == '0));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int NCH = 48
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  input  logic           ien,
  output logic           irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien & (|pend);
  end

  assign irq_o = irq_q;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ien));

  // R7
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pend == '0) |-> !irq_q);
endmodule

// File: rtl/evt_capture_top.sv
module evt_capture_top
  import evt_pkg::*;
#(
  parameter int NCH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   din,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [NCH-1:0]   wr_data,
  output logic [NCH-1:0]   pend_o,
  output logic             irq_o
);
  logic [NCH-1:0] pol, en, cos, clr, hit, pend;
  logic           ien;

  evt_cfg_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pol_o(pol), .en_o(en), .cos_o(cos), .clr_o(clr), .ien_o(ien)
  );

  evt_edge_detect #(.NCH(NCH)) u_edge (
    .clk(clk), .rst(rst), .din(din), .pol(pol), .en(en), .cos(cos), .hit_o(hit)
  );

  evt_pend_bank #(.NCH(NCH)) u_pend (
    .clk(clk), .rst(rst), .hit(hit), .clr(clr), .pend_o(pend)
  );

  evt_irq_gen #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst), .pend(pend), .ien(ien), .irq_o(irq_o)
  );

  assign pend_o = pend;

  // R3
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));
endmodule

// File: tb/evt_capture_top_tb.sv
module evt_capture_top_tb;
  localparam int NCH = 48;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] din = '0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_sel = '0;
  logic [NCH-1:0] wr_data = '0;
  logic [NCH-1:0] pend_o;
  logic           irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [NCH-1:0] exp_p = '0;
  logic           ien   = 1'b0;

  logic [NCH-1:0] exp_p_q[$];
  logic           exp_i_q[$];
  string          tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  evt_capture_top #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (tag_q.size() > 0) begin
        logic [NCH-1:0] ep;
        logic           ei;
        string          t;
        ep = exp_p_q.pop_front();
        ei = exp_i_q.pop_front();
        t  = tag_q.pop_front();
        n_tests++;
        if (pend_o !== ep) begin
          n_fail++;
          $display("FAIL %s pend: actual %h expected %h", t, pend_o, ep);
        end
        n_tests++;
        if (irq_o !== ei) begin
          n_fail++;
          $display("FAIL %s irq: actual %b expected %b", t, irq_o, ei);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic wr(input logic [2:0] a, input logic [NCH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [NCH-1:0] v);
    @(negedge clk);
    din = v;
    @(negedge clk);
  endtask

  task automatic drive_and_clear(input logic [NCH-1:0] v, input logic [NCH-1:0] c);
    @(negedge clk);
    din = v; wr_en = 1'b1; wr_sel = 3'd3; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expect_state(input string t);
    repeat (3) @(negedge clk);
    exp_p_q.push_back(exp_p);
    exp_i_q.push_back(ien & (|exp_p));
    tag_q.push_back(t);
    wait (tag_q.size() == 0);
  endtask

  initial begin
    logic [NCH-1:0] b47;
    b47 = '0;
    b47[NCH-1] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_state("R1 reset");

    wr(3'd1, 48'h1);
    drive(48'h1);                       // rising, default polarity falling
    expect_state("R1 default polarity");
    drive(48'h0);
    exp_p = 48'h1;
    expect_state("R2 falling latch, R7 poll with irq off");

    wr(3'd4, 48'h1); ien = 1'b1;
    expect_state("R7 irq on");

    wr(3'd3, 48'h0);
    expect_state("R5 write zero");
    wr(3'd3, 48'h1); exp_p = '0;
    expect_state("R5 write one");

    wr(3'd0, 48'hA);
    wr(3'd1, 48'h3);
    drive(48'h2); exp_p = 48'h2;
    expect_state("R2 rising latch");

    drive(48'h6);
    drive(48'h2);
    expect_state("R3 disabled channel");

    drive(48'hA);                       // bit3 rises while disabled
    wr(3'd1, 48'hB);
    expect_state("R8 no stale edge");
    drive(48'h2);
    drive(48'hA); exp_p = 48'hA;
    expect_state("R8 fresh edge");

    wr(3'd3, '1); exp_p = '0;
    expect_state("R5 clear all");

    wr(3'd2, 48'h10);
    wr(3'd1, 48'h1B);
    drive(48'h1A); exp_p = 48'h10;
    expect_state("R4 cos rising");
    wr(3'd3, 48'h10); exp_p = '0;
    drive(48'hA); exp_p = 48'h10;
    expect_state("R4 cos falling");

    wr(3'd3, 48'h10); exp_p = '0;
    drive(48'hB);
    drive_and_clear(48'hA, 48'h1); exp_p = 48'h1;
    expect_state("R6 edge beats clear");

    wr(3'd0, 48'hA | b47);
    wr(3'd1, 48'h1B | b47);
    drive(48'hA | b47); exp_p = 48'h1 | b47;
    expect_state("R2 top channel");

    wr(3'd4, 48'h0); ien = 1'b0;
    expect_state("R7 irq gated, flags kept");

    wr(3'd3, '1); exp_p = '0;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    drive(48'h0);
    drive(48'h1);
    drive(48'h0);
    expect_state("R1 reset clears enables");

    finish_run();
  end
endmodule